// File: doc/BRIEF.md
# Byte-wide SPI master with register access

This block is a full-duplex SPI master that a host drives through a small bank of 8-bit registers. Every byte the host writes to the data port enters a four-entry transmit queue. The shift engine takes bytes from that queue one at a time and shifts each one out MSB first on MOSI. While it does so, it assembles the byte arriving on MISO and places it in a four-entry receive queue, which the host reads back through the same data port.

The serial clock is derived from the system clock. A 4-bit divider code selects one of a set of power-of-two ratios whose order is not monotonic. The low two bits of the code live in the control register and the high two bits live in the extension register. Clock polarity and phase are programmable. Four active-low select lines are driven entirely from a software register, in which each line has its own enable bit and its own level bit.

A slave-select input is watched while the core acts as master. If that input is pulled low, the block records a mode fault, leaves master mode, abandons the byte in flight and can raise an interrupt.

Top module: `spi_byte_master`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x05, SCK is low, all four select outputs are high and the interrupt is low.
- R2: The host address decodes as follows. 0 is control, 1 is status, 2 is data, 3 is extension, 4 is parameter, 5 is soft select and 6 is timing. Control, extension, parameter, soft select and timing read back the last byte written. Address 7 reads 0x00.
- R3: The divider code is {extension[1:0], control[1:0]}. Codes 0 to 11 give SCK periods of 2, 4, 16, 32, 8, 64, 128, 256, 512, 1024, 2048 and 4096 system clocks, and codes 12 to 15 give 4096. Each SCK level lasts half the period.
- R4: Control bit 3 (CPOL) sets the idle SCK level and control bit 2 (CPHA) sets the phase. A byte takes 16 SCK edges, and bits go out MSB first. With CPHA=0, MISO is sampled on the leading edges and MOSI changes on the trailing edges, with bit 7 presented before the first edge. With CPHA=1, MOSI changes on the leading edges and MISO is sampled on the trailing edges.
- R5: Bytes written to address 2 are sent in write order. Each received byte is queued, and reads of address 2 return the received bytes in order, removing one per read.
- R6: Status bits are: 0 receive queue empty, 1 receive queue full (4 bytes), 2 transmit queue empty, 3 transmit queue full (4 bytes), 4 mode fault, 6 write collision, 7 shifter busy. Bit 5 reads 0.
- R7: A new byte does not start while the receive queue holds 4 bytes. Shifting resumes once the host has read a byte.
- R8: A data write while the transmit queue is full is dropped and sets status bit 6. Writing status with bit 6 set clears that flag.
- R9: Reading address 2 while the receive queue is empty returns the last byte read from the queue (0x00 after reset) and changes no status.
- R10: For each line n from 0 to 3, soft-select bit n set drives line n to the level in bit n+4. When bit n is clear, line n is held high.
- R11: When control bit 6 (enable) and bit 4 (master) are set and the slave-select input is low at a clock edge, status bit 4 is set, control bit 4 is cleared and any byte in flight is abandoned, with SCK returning to the CPOL level. The interrupt output equals control bit 7 AND status bit 4. Writing status with bit 4 set clears the flag.
- R12: While control bit 6 is clear, both queues are held empty, data writes are discarded and the shifter stays idle.
- R13: After writing 0x51 to control and 0x00 to extension, a data write produces a mode-0 byte with SCK at one quarter of the system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Host access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 4 | Software-driven select lines |
| ss_in_n | input | 1 | Slave-select sense, low causes a mode fault |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is a full receive queue that holds back a full transmit queue. This is the only state in which a data write collides and the shifter waits on the reader. The stimulus writes four bytes and lets all of them complete without reading, so the receive queue fills. It then refills the transmit queue and writes a fifth byte. After that it reads the bytes one at a time and watches shifting resume. The mode fault is forced in the middle of a slow byte, so that the abort of a running transfer is visible on SCK. A behavioural reference model in the bench follows every clock and is compared against the outputs.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int BYTE_W     = 8;
    localparam int FIFO_DEPTH = 4;
    localparam int CS_LINES   = 4;
    localparam int DIVSEL_W   = 4;
    localparam int MAX_SHIFT  = 12;
    localparam int HALF_CNT_W = MAX_SHIFT;

    typedef enum logic [2:0] {
        RA_CTRL   = 3'd0,
        RA_STAT   = 3'd1,
        RA_DATA   = 3'd2,
        RA_EXT    = 3'd3,
        RA_PARAM  = 3'd4,
        RA_SELECT = 3'd5,
        RA_TIMING = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic       irq_en;
        logic       core_en;
        logic       spare;
        logic       master;
        logic       cpol;
        logic       cpha;
        logic [1:0] div_lo;
    } ctrl_t;

    typedef struct packed {
        logic busy;
        logic wcol;
        logic spare;
        logic modf;
        logic tx_full;
        logic tx_empty;
        logic rx_full;
        logic rx_empty;
    } stat_t;

    // log2 of the SCK period in system clocks for a divider code
    function automatic logic [3:0] div_shift(input logic [DIVSEL_W-1:0] code);
        logic [3:0] s;
        case (code)
            4'd0:    s = 4'd1;
            4'd1:    s = 4'd2;
            4'd2:    s = 4'd4;
            4'd3:    s = 4'd5;
            4'd4:    s = 4'd3;
            default: s = (code >= 4'd11) ? 4'(MAX_SHIFT) : (code + 4'd1);
        endcase
        return s;
    endfunction

    // terminal count of the half-period counter
    function automatic logic [HALF_CNT_W-1:0] half_limit(input logic [DIVSEL_W-1:0] code);
        logic [HALF_CNT_W:0] one_half;
        one_half = (HALF_CNT_W+1)'(1) << (div_shift(code) - 4'd1);
        return HALF_CNT_W'(one_half - (HALF_CNT_W+1)'(1));
    endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_p, wr_p;
    logic [CW-1:0] cnt;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rd_p <= '0;
            wr_p <= '0;
            cnt  <= '0;
        end else begin
            if (push) wr_p <= bump(wr_p);
            if (pop)  rd_p <= bump(rd_p);
            case ({push, pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push && !clr && !rst) mem[wr_p] <= din;
    end

    assign dout  = mem[rd_p];
    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst || clr)
        push |-> !full);
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst || clr)
        pop |-> !empty);

endmodule

// File: rtl/spim_clkdiv.sv
module spim_clkdiv
    import spim_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic [DIVSEL_W-1:0] code,
    output logic                tick
);
    logic [HALF_CNT_W-1:0] cnt;
    logic [HALF_CNT_W-1:0] limit;

    assign limit = half_limit(code);
    assign tick  = run && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + HALF_CNT_W'(1);
    end

    // R3: the counter never runs past the selected terminal count
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (run && $stable(code) && $past(run)) |-> (cnt <= limit));

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic         start,
    input  logic [W-1:0] tx_byte,
    input  logic         cpol,
    input  logic         cpha,
    input  logic         tick,
    input  logic         miso,
    output logic         busy,
    output logic         sck,
    output logic         mosi,
    output logic         done,
    output logic [W-1:0] rx_byte
);
    localparam int EDGES  = 2 * W;
    localparam int EDGE_W = $clog2(EDGES);

    logic [EDGE_W-1:0] edge_q;
    logic [W-1:0]      tx_q, rx_q;
    logic              lead, samp, shift, last;

    always_comb begin
        lead    = ~edge_q[0];
        samp    = cpha ? ~lead : lead;
        last    = (edge_q == EDGE_W'(EDGES - 1));
        shift   = cpha ? lead : (~lead && !last);
        rx_byte = samp ? {rx_q[W-2:0], miso} : rx_q;
        done    = busy && enable && tick && last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            edge_q <= '0;
            sck    <= 1'b0;
            mosi   <= 1'b0;
            tx_q   <= '0;
            rx_q   <= '0;
        end else if (!busy) begin
            sck <= cpol;
            if (start && enable) begin
                busy   <= 1'b1;
                edge_q <= '0;
                rx_q   <= '0;
                if (!cpha) begin
                    mosi <= tx_byte[W-1];
                    tx_q <= {tx_byte[W-2:0], 1'b0};
                end else begin
                    tx_q <= tx_byte;
                end
            end
        end else if (!enable) begin
            busy <= 1'b0;
            sck  <= cpol;
        end else if (tick) begin
            sck  <= ~sck;
            rx_q <= rx_byte;
            if (shift) begin
                mosi <= tx_q[W-1];
                tx_q <= {tx_q[W-2:0], 1'b0};
            end
            if (last) busy   <= 1'b0;
            else      edge_q <= edge_q + EDGE_W'(1);
        end
    end

    // R4: an idle shifter holds SCK at the polarity level
    assert_sck_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy) && $stable(cpol)) |-> (sck == cpol));
    // R4: a byte ends with SCK back at its idle level
    assert_frame_end_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> (sck == cpol));

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
    import spim_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [2:0]          bus_addr,
    input  logic [BYTE_W-1:0]   bus_wdata,
    output logic [BYTE_W-1:0]   bus_rdata,
    output logic                sck_o,
    output logic                mosi_o,
    input  logic                miso_i,
    output logic [CS_LINES-1:0] cs_n_o,
    input  logic                ss_in_n,
    output logic                irq_o
);
    ctrl_t             ctrl_q;
    logic [BYTE_W-1:0] ext_q, param_q, select_q, timing_q, last_rd_q;
    logic              modf_q, wcol_q;

    logic wr, rd, data_wr, data_rd, stat_wr;
    logic en, run, fault, start;
    logic tx_push, tx_pop, tx_empty, tx_full;
    logic rx_push, rx_pop, rx_empty, rx_full;
    logic [BYTE_W-1:0] tx_head, rx_head, rx_in;
    logic busy, tick;
    logic [DIVSEL_W-1:0] div_code;
    stat_t stat;

    assign wr      = bus_sel && bus_we;
    assign rd      = bus_sel && !bus_we;
    assign data_wr = wr && (bus_addr == RA_DATA);
    assign data_rd = rd && (bus_addr == RA_DATA);
    assign stat_wr = wr && (bus_addr == RA_STAT);

    assign en       = ctrl_q.core_en;
    assign run      = en && ctrl_q.master;
    assign fault    = run && !ss_in_n;
    assign div_code = {ext_q[1:0], ctrl_q.div_lo};

    assign tx_push = data_wr && en && !tx_full;
    assign start   = run && !tx_empty && !rx_full && !busy;
    assign tx_pop  = start;
    assign rx_pop  = data_rd && !rx_empty;

    spim_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .clr(!en),
        .push(tx_push), .din(bus_wdata), .pop(tx_pop),
        .dout(tx_head), .empty(tx_empty), .full(tx_full)
    );

    spim_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .clr(!en),
        .push(rx_push), .din(rx_in), .pop(rx_pop),
        .dout(rx_head), .empty(rx_empty), .full(rx_full)
    );

    spim_clkdiv u_div (
        .clk(clk), .rst(rst), .run(busy && run), .code(div_code), .tick(tick)
    );

    spim_shifter #(.W(BYTE_W)) u_shift (
        .clk(clk), .rst(rst), .enable(run), .start(start),
        .tx_byte(tx_head), .cpol(ctrl_q.cpol), .cpha(ctrl_q.cpha),
        .tick(tick), .miso(miso_i), .busy(busy), .sck(sck_o),
        .mosi(mosi_o), .done(rx_push), .rx_byte(rx_in)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            ext_q     <= '0;
            param_q   <= '0;
            select_q  <= '0;
            timing_q  <= '0;
            last_rd_q <= '0;
            modf_q    <= 1'b0;
            wcol_q    <= 1'b0;
        end else begin
            if (wr) begin
                case (bus_addr)
                    RA_CTRL:   ctrl_q   <= ctrl_t'(bus_wdata);
                    RA_EXT:    ext_q    <= bus_wdata;
                    RA_PARAM:  param_q  <= bus_wdata;
                    RA_SELECT: select_q <= bus_wdata;
                    RA_TIMING: timing_q <= bus_wdata;
                    default: ;
                endcase
            end
            if (fault) ctrl_q.master <= 1'b0;
            if (fault)                        modf_q <= 1'b1;
            else if (stat_wr && bus_wdata[4]) modf_q <= 1'b0;
            if (data_wr && en && tx_full)     wcol_q <= 1'b1;
            else if (stat_wr && bus_wdata[6]) wcol_q <= 1'b0;
            if (rx_pop) last_rd_q <= rx_head;
        end
    end

    always_comb begin
        stat          = '0;
        stat.busy     = busy;
        stat.wcol     = wcol_q;
        stat.modf     = modf_q;
        stat.tx_full  = tx_full;
        stat.tx_empty = tx_empty;
        stat.rx_full  = rx_full;
        stat.rx_empty = rx_empty;
        case (bus_addr)
            RA_CTRL:   bus_rdata = ctrl_q;
            RA_STAT:   bus_rdata = stat;
            RA_DATA:   bus_rdata = rx_empty ? last_rd_q : rx_head;
            RA_EXT:    bus_rdata = ext_q;
            RA_PARAM:  bus_rdata = param_q;
            RA_SELECT: bus_rdata = select_q;
            RA_TIMING: bus_rdata = timing_q;
            default:   bus_rdata = '0;
        endcase
    end

    generate
        for (genvar n = 0; n < CS_LINES; n++) begin : g_sel
            assign cs_n_o[n] = select_q[n] ? select_q[n + CS_LINES] : 1'b1;
        end
    endgenerate

    assign irq_o = ctrl_q.irq_en && modf_q;

    assert_wcol_set_R8: assert property (@(posedge clk) disable iff (rst)
        (data_wr && en && tx_full) |=> wcol_q);
    assert_modf_drops_master_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(modf_q) |-> !ctrl_q.master);
    assert_rx_stall_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(!rx_full));
    assert_disable_flush_R12: assert property (@(posedge clk) disable iff (rst)
        !en |=> (tx_empty && rx_empty && !busy));

endmodule

// File: tb/spi_byte_master_tb.sv
module spi_byte_master_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0, bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sck_o, mosi_o, miso_i = 1'b0, irq_o, ss_in_n = 1'b1;
    logic [3:0] cs_n_o;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    spi_byte_master u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i), .cs_n_o(cs_n_o),
        .ss_in_n(ss_in_n), .irq_o(irq_o)
    );

    // ---------------- reference model ----------------
    logic [7:0] m_ctrl, m_ext, m_par, m_sel, m_tim, m_last, m_cur, m_sl, m_cap;
    bit         m_modf, m_wcol, m_act, m_sck;
    int         m_m, m_h, m_xn;
    logic [7:0] txq[$], rxq[$];

    function automatic int period(input int c);
        case (c)
            0: return 2;
            1: return 4;
            2: return 16;
            3: return 32;
            4: return 8;
            default: return (c >= 11) ? 4096 : (1 << (c + 1));
        endcase
    endfunction

    function automatic logic [7:0] slave_byte(input int k);
        return 8'(8'h3C ^ (k * 91));
    endfunction

    function automatic logic [7:0] m_status();
        return {m_act, m_wcol, 1'b0, m_modf, txq.size() == 4, txq.size() == 0,
                rxq.size() == 4, rxq.size() == 0};
    endfunction

    function automatic logic [7:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_ctrl;
            3'd1: return m_status();
            3'd2: return (rxq.size() > 0) ? rxq[0] : m_last;
            3'd3: return m_ext;
            3'd4: return m_par;
            3'd5: return m_sel;
            3'd6: return m_tim;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [3:0] m_cs();
        logic [3:0] r;
        for (int n = 0; n < 4; n++) r[n] = m_sel[n] ? m_sel[n + 4] : 1'b1;
        return r;
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    int  p_tx, p_rx, k;
    bit  p_en, p_mst, p_pol, done;

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = 0; m_ext = 0; m_par = 0; m_sel = 0; m_tim = 0; m_last = 0;
            m_modf = 0; m_wcol = 0; m_act = 0; m_sck = 0; m_m = 0; m_xn = 0;
            m_h = 1; m_cap = 0; m_cur = 0; m_sl = 0;
            txq.delete(); rxq.delete();
        end else begin
            p_tx = txq.size(); p_rx = rxq.size();
            p_en = m_ctrl[6]; p_mst = m_ctrl[4]; p_pol = m_ctrl[3];
            m_h = period({m_ext[1:0], m_ctrl[1:0]}) / 2;
            done = 0;
            if (m_act) begin
                if (!(p_en && p_mst)) m_act = 0;
                else begin
                    m_m++;
                    if (m_m == 16 * m_h) begin m_act = 0; done = 1; end
                end
            end else if (p_en && p_mst && p_tx > 0 && p_rx < 4) begin
                m_cur = txq.pop_front(); m_act = 1; m_m = 0;
                m_sl = slave_byte(m_xn); m_xn++; m_cap = 0;
            end
            if (bus_sel && !bus_we && bus_addr == 3'd2 && p_rx > 0) m_last = rxq.pop_front();
            if (done) begin
                rxq.push_back(m_sl);
                check(m_cap, m_cur, "R4 R5 MOSI byte as seen by slave");
            end
            if (bus_sel && bus_we) begin
                case (bus_addr)
                    3'd0: m_ctrl = bus_wdata;
                    3'd1: begin
                        if (bus_wdata[4]) m_modf = 0;
                        if (bus_wdata[6]) m_wcol = 0;
                    end
                    3'd2: if (p_en) begin
                        if (p_tx < 4) txq.push_back(bus_wdata); else m_wcol = 1;
                    end
                    3'd3: m_ext = bus_wdata;
                    3'd4: m_par = bus_wdata;
                    3'd5: m_sel = bus_wdata;
                    3'd6: m_tim = bus_wdata;
                    default: ;
                endcase
            end
            if (p_en && p_mst && !ss_in_n) begin m_modf = 1; m_ctrl[4] = 0; end
            if (!p_en) begin txq.delete(); rxq.delete(); end
            m_sck = m_act ? (p_pol ^ (((m_m / m_h) % 2) == 1)) : p_pol;
        end
        #2;
        if (!rst) begin
            check({5'd0, sck_o, irq_o, 1'b0} | {cs_n_o, 4'd0},
                  {5'd0, m_sck, m_ctrl[7] & m_modf, 1'b0} | {m_cs(), 4'd0},
                  "R3 R4 R10 R11 per-clock sck/select/irq");
            miso_i = m_act ? m_sl[7 - (((m_m / m_h) / 2) > 7 ? 7 : ((m_m / m_h) / 2))] : 1'b0;
            if (m_act && ((m_m + 1) % m_h) == 0) begin
                k = m_m / m_h;
                if (m_ctrl[2] ? (k % 2 == 1) : (k % 2 == 0)) m_cap = {m_cap[6:0], mosi_o};
            end
        end
    end

    // ---------------- bus tasks ----------------
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd_model(input logic [2:0] a, input string tag);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #1;
        check(bus_rdata, m_read(a), tag);
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic rd_lit(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #1;
        check(bus_rdata, exp, tag);
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic wait_idle();
        forever begin
            @(posedge clk); #3;
            if (!m_act && txq.size() == 0) break;
        end
    endtask

    // ---------------- stimulus ----------------
    int hi_cnt;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset state
        rd_lit(3'd1, 8'h05, "R1 status after reset");
        rd_lit(3'd0, 8'h00, "R1 control after reset");
        check({4'd0, cs_n_o}, 8'h0F, "R1 selects high after reset");
        check({7'd0, sck_o}, 8'h00, "R1 sck low after reset");
        check({7'd0, irq_o}, 8'h00, "R1 irq low after reset");
        rd_lit(3'd2, 8'h00, "R9 empty read after reset");

        // R2 register map
        wr(3'd4, 8'h5A); wr(3'd6, 8'h3C); wr(3'd3, 8'hF0);
        rd_lit(3'd4, 8'h5A, "R2 parameter readback");
        rd_lit(3'd6, 8'h3C, "R2 timing readback");
        rd_lit(3'd3, 8'hF0, "R2 extension readback");
        rd_lit(3'd7, 8'h00, "R2 unused address");

        // R13 initialisation values give mode 0 at /4
        wr(3'd0, 8'h51); wr(3'd3, 8'h00);
        wr(3'd2, 8'hA7);
        hi_cnt = 0;
        forever begin
            @(posedge clk); #3;
            if (sck_o) hi_cnt++;
            if (!m_act && txq.size() == 0) break;
        end
        check(8'(hi_cnt), 8'd16, "R13 sck high clocks per byte at /4");
        rd_lit(3'd2, slave_byte(0), "R13 R5 received byte");

        // R3 divider sweep
        for (int c = 0; c <= 12; c++) begin
            wr(3'd3, 8'(c >> 2));
            wr(3'd0, 8'h50 | 8'(c & 3));
            wr(3'd2, 8'(8'h81 + c));
            wait_idle();
            rd_model(3'd2, "R3 R5 byte at divider code");
        end

        // R4 modes 1..3
        wr(3'd3, 8'h00);
        for (int md = 1; md < 4; md++) begin
            wr(3'd0, 8'h51 | 8'(md << 2));
            repeat (3) @(negedge clk);
            wr(3'd2, 8'(8'hC3 ^ md)); wr(3'd2, 8'(8'h1E + md));
            wait_idle();
            rd_model(3'd2, "R4 R5 first byte in mode");
            rd_model(3'd2, "R4 R5 second byte in mode");
        end

        // R7 R8 stall and collision
        wr(3'd0, 8'h51);
        for (int i = 0; i < 4; i++) wr(3'd2, 8'(8'h10 + i));
        wait_idle();
        for (int i = 0; i < 4; i++) wr(3'd2, 8'(8'h20 + i));
        wr(3'd2, 8'hEE);
        rd_lit(3'd1, 8'h4A, "R6 R8 full queues with collision");
        repeat (60) @(negedge clk);
        rd_lit(3'd1, 8'h4A, "R7 shifter stalled on full receive queue");
        for (int i = 0; i < 4; i++) rd_model(3'd2, "R5 R7 ordered read during drain");
        wait_idle();
        for (int i = 0; i < 4; i++) rd_model(3'd2, "R5 second batch read");
        wr(3'd1, 8'h40);
        rd_lit(3'd1, 8'h05, "R8 collision cleared");

        // R9 empty reads
        rd_model(3'd2, "R9 empty read repeats last");
        rd_lit(3'd2, slave_byte(m_xn - 1), "R9 empty read last value");
        rd_lit(3'd1, 8'h05, "R9 status unchanged");

        // R10 soft selects
        wr(3'd5, 8'h01);
        check({4'd0, cs_n_o}, 8'h0E, "R10 line 0 asserted");
        wr(3'd5, 8'h11);
        check({4'd0, cs_n_o}, 8'h0F, "R10 line 0 released");
        wr(3'd5, 8'h2A);
        check({4'd0, cs_n_o}, 8'h07, "R10 lines 1 and 3 levels");

        // R11 mode fault mid-byte
        wr(3'd3, 8'h01); wr(3'd0, 8'hD1);
        wr(3'd2, 8'h77);
        repeat (100) @(negedge clk);
        ss_in_n = 0;
        @(negedge clk);
        ss_in_n = 1;
        repeat (2) @(negedge clk);
        check({7'd0, irq_o}, 8'h01, "R11 irq raised");
        rd_lit(3'd1, 8'h15, "R11 fault flag, byte abandoned");
        rd_lit(3'd0, 8'hC1, "R11 master bit cleared");
        wr(3'd1, 8'h10);
        check({7'd0, irq_o}, 8'h00, "R11 irq cleared");
        rd_lit(3'd1, 8'h05, "R11 status after clear");

        // R12 disable flushes
        wr(3'd0, 8'h51);
        wr(3'd2, 8'h31); wr(3'd2, 8'h32); wr(3'd2, 8'h33);
        repeat (20) @(negedge clk);
        wr(3'd0, 8'h11);
        rd_lit(3'd1, 8'h05, "R12 queues flushed");
        wr(3'd2, 8'h44);
        wr(3'd0, 8'h51);
        repeat (10) @(negedge clk);
        rd_lit(3'd1, 8'h05, "R12 write while disabled discarded");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule